// File: doc/BRIEF.md
# Segment Address Translator

This block turns a logical address (a segment register number plus a 32-bit offset) into a 32-bit linear address. It uses a small set of six segment registers. Each register keeps a cached copy of a segment descriptor: the base, an inclusive byte limit, a present bit, a code/data bit, a read-or-write permission bit and a privilege level. Software-side logic writes a descriptor into a register through the load port. From then on every translation through that register uses only the cached copy, and no memory is read.

Each request carries an access kind (read, write or fetch) and the current privilege level. The block checks them against the cached rights and limit. If every check passes, it returns base + offset modulo 2^32. If a check fails, it returns a protection fault and a cause code. The result is registered and appears one cycle after the request.

Top module: `seg_xlate`

## Requirements
- R1: After reset every segment register holds an absent descriptor, and all outputs are zero while reset is held.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. With no request, `rsp_valid`, `rsp_fault`, `rsp_cause` and `rsp_lin` are all zero.
- R3: A request that passes all checks returns `rsp_lin` = base + offset, wrapped modulo 2^32.
- R4: The limit is inclusive. An offset equal to the limit passes. An offset above the limit faults with cause 4.
- R5: These requests fault with cause 5: a write (kind 1) to a code segment, a write to a data segment whose permission bit is 0, a fetch (kind 2) from a data segment, and any request with kind 3.
- R6: For a code segment the permission bit means readable. A read (kind 0) of a code segment with that bit at 0 faults with cause 5, while a fetch from it passes.
- R7: A request whose privilege level is numerically greater than the descriptor's level faults with cause 3.
- R8: A request to segment number 6 or 7 faults with cause 2. A request through a register holding an absent descriptor faults with cause 1.
- R9: When several checks fail, the cause reported follows this order, first match wins: 2, 1, 3, 5, 4.
- R10: A faulting response has `rsp_lin` equal to zero.
- R11: A descriptor load takes effect for requests in the following cycle. A request in the same cycle as a load to the same register sees the old descriptor.
- R12: A descriptor with base 0 and limit FFFF_FFFFh passes every offset through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write a descriptor into a segment register |
| ld_seg | input | 3 | Register number being loaded |
| ld_base | input | 32 | Segment base |
| ld_limit | input | 32 | Inclusive byte limit |
| ld_present | input | 1 | Descriptor valid |
| ld_code | input | 1 | 1 = code segment, 0 = data segment |
| ld_rw | input | 1 | Code: readable; data: writable |
| ld_dpl | input | 2 | Descriptor privilege level |
| req_valid | input | 1 | Translation request |
| req_seg | input | 3 | Segment register number (0..5 valid) |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| req_cpl | input | 2 | Current privilege level |
| req_off | input | 32 | Offset within the segment |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Protection fault |
| rsp_cause | output | 3 | 0 none, 1 absent, 2 bad register, 3 privilege, 4 limit, 5 access kind |
| rsp_lin | output | 32 | Linear address, zero on fault |

## Verification
The hardest situation to reach is a request that fails several checks at once, because only one cause can be reported. The stimulus builds descriptors that fail privilege, access kind and limit together, and checks that the order of R9 is kept. The same-cycle collision of a load and a request to the same register also takes deliberate timing. The bench drives both in one cycle, expects the old descriptor, and then repeats the request in the next cycle to see the new one. A long pseudo-random run mixes loads and requests, including wrapping bases, against the cycle model.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W = 32;
  localparam int PL_W   = 2;

  typedef struct packed {
    logic              present;
    logic              code;
    logic              rw;
    logic [PL_W-1:0]   dpl;
    logic [ADDR_W-1:0] limit;
    logic [ADDR_W-1:0] base;
  } seg_desc_t;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_ABSENT = 3'd1,
    CAUSE_INDEX  = 3'd2,
    CAUSE_PRIV   = 3'd3,
    CAUSE_LIMIT  = 3'd4,
    CAUSE_KIND   = 3'd5
  } fault_cause_e;
endpackage

// File: rtl/seg_desc_file.sv
module seg_desc_file
  import seg_xlate_pkg::*;
#(
  parameter int NSEG = 6,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  seg_desc_t     ld_desc,
  input  logic [IW-1:0] rd_idx,
  output seg_desc_t     rd_desc,
  output logic          rd_idx_ok
);
  seg_desc_t ent_q [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) ent_q[i] <= '0;
      else if (ld_en && ld_idx == IW'(i)) ent_q[i] <= ld_desc;
    end

    // R11: a load lands in the addressed register one cycle later
    a_r11_load_lands: assert property (@(posedge clk) disable iff (rst)
      (ld_en && ld_idx == IW'(i)) |=> (ent_q[i] == $past(ld_desc)));
  end

  always_comb begin
    rd_desc   = '0;
    rd_idx_ok = 1'b0;
    for (int i = 0; i < NSEG; i++) begin
      if (rd_idx == IW'(i)) begin
        rd_desc   = ent_q[i];
        rd_idx_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/seg_rights_check.sv
module seg_rights_check
  import seg_xlate_pkg::*;
(
  input  seg_desc_t         desc,
  input  logic              idx_ok,
  input  logic [1:0]        kind,
  input  logic [PL_W-1:0]   cpl,
  input  logic [ADDR_W-1:0] off,
  output fault_cause_e      cause
);
  logic kind_bad;

  always_comb begin
    unique case (acc_kind_e'(kind))
      KIND_READ:  kind_bad = desc.code && !desc.rw;
      KIND_WRITE: kind_bad = desc.code || !desc.rw;
      KIND_FETCH: kind_bad = !desc.code;
      default:    kind_bad = 1'b1;
    endcase
  end

  always_comb begin
    if (!idx_ok)              cause = CAUSE_INDEX;
    else if (!desc.present)   cause = CAUSE_ABSENT;
    else if (cpl > desc.dpl)  cause = CAUSE_PRIV;
    else if (kind_bad)        cause = CAUSE_KIND;
    else if (off > desc.limit) cause = CAUSE_LIMIT;
    else                      cause = CAUSE_NONE;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NSEG = 6,
  localparam int IW = $clog2(NSEG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [IW-1:0]     ld_seg,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic [ADDR_W-1:0] ld_limit,
  input  logic              ld_present,
  input  logic              ld_code,
  input  logic              ld_rw,
  input  logic [PL_W-1:0]   ld_dpl,
  input  logic              req_valid,
  input  logic [IW-1:0]     req_seg,
  input  logic [1:0]        req_kind,
  input  logic [PL_W-1:0]   req_cpl,
  input  logic [ADDR_W-1:0] req_off,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_lin
);
  seg_desc_t    ld_desc, rd_desc;
  logic         rd_idx_ok;
  fault_cause_e cause;

  always_comb begin
    ld_desc.present = ld_present;
    ld_desc.code    = ld_code;
    ld_desc.rw      = ld_rw;
    ld_desc.dpl     = ld_dpl;
    ld_desc.limit   = ld_limit;
    ld_desc.base    = ld_base;
  end

  seg_desc_file #(.NSEG(NSEG), .IW(IW)) desc_file_i (
    .clk(clk), .rst(rst),
    .ld_en(ld_en), .ld_idx(ld_seg), .ld_desc(ld_desc),
    .rd_idx(req_seg), .rd_desc(rd_desc), .rd_idx_ok(rd_idx_ok)
  );

  seg_rights_check rights_i (
    .desc(rd_desc), .idx_ok(rd_idx_ok), .kind(req_kind),
    .cpl(req_cpl), .off(req_off), .cause(cause)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
      rsp_lin   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && (cause != CAUSE_NONE);
      rsp_cause <= req_valid ? cause : CAUSE_NONE;
      rsp_lin   <= (req_valid && cause == CAUSE_NONE) ? rd_desc.base + req_off : '0;
    end
  end

  // R2: one response per request, one cycle later
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R10: faults carry no address
  a_r10_fault_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_lin == '0));
  // R8: out-of-range register number
  a_r8_bad_index: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_seg >= IW'(NSEG)) |=> (rsp_fault && rsp_cause == CAUSE_INDEX));
  // R3: passing response is base plus offset of the request
  a_r3_sum: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cause == CAUSE_NONE) |=> (rsp_lin == $past(rd_desc.base) + $past(req_off)));
  // R4: passing response never lies beyond the limit
  a_r4_limit: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rd_idx_ok && req_off > rd_desc.limit) |=> rsp_fault);
endmodule

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_en, ld_present, ld_code, ld_rw;
  logic [2:0]  ld_seg, req_seg;
  logic [31:0] ld_base, ld_limit, req_off;
  logic [1:0]  ld_dpl, req_kind, req_cpl;
  logic        req_valid;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_cause;
  logic [31:0] rsp_lin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_base [6];
  logic [31:0] m_lim  [6];
  logic        m_pres [6];
  logic        m_code [6];
  logic        m_rw   [6];
  logic [1:0]  m_dpl  [6];

  always #5 clk = ~clk;

  seg_xlate dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_seg(ld_seg), .ld_base(ld_base),
    .ld_limit(ld_limit), .ld_present(ld_present), .ld_code(ld_code), .ld_rw(ld_rw),
    .ld_dpl(ld_dpl), .req_valid(req_valid), .req_seg(req_seg), .req_kind(req_kind),
    .req_cpl(req_cpl), .req_off(req_off), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause), .rsp_lin(rsp_lin)
  );

  task automatic compare(string tag, logic ev, logic ef, logic [2:0] ec, logic [31:0] el);
    checks++;
    if (rsp_valid !== ev || rsp_fault !== ef || rsp_cause !== ec || rsp_lin !== el) begin
      errors++;
      $display("FAIL %s: got v=%0b f=%0b c=%0d lin=%h, expected v=%0b f=%0b c=%0d lin=%h",
               tag, rsp_valid, rsp_fault, rsp_cause, rsp_lin, ev, ef, ec, el);
    end
  endtask

  // one clock: compute expectation from requirements, advance, compare
  task automatic tick(string tag);
    logic ev, ef;
    logic [2:0] ec;
    logic [31:0] el;
    logic bad;
    int s;
    ev = req_valid; ec = 3'd0; el = 32'h0;
    if (req_valid) begin
      s = int'(req_seg);
      if (s > 5) ec = 3'd2;                         // R8
      else if (!m_pres[s]) ec = 3'd1;               // R8
      else if (req_cpl > m_dpl[s]) ec = 3'd3;       // R7
      else begin
        case (req_kind)
          2'd0: bad = m_code[s] && !m_rw[s];        // R6
          2'd1: bad = m_code[s] || !m_rw[s];        // R5
          2'd2: bad = !m_code[s];                   // R5
          default: bad = 1'b1;
        endcase
        if (bad) ec = 3'd5;
        else if (req_off > m_lim[s]) ec = 3'd4;     // R4
        else el = m_base[s] + req_off;              // R3
      end
    end
    ef = (ec != 3'd0);
    if (ld_en && ld_seg < 3'd6) begin              // R11: old descriptor used above
      m_base[ld_seg] = ld_base; m_lim[ld_seg] = ld_limit; m_pres[ld_seg] = ld_present;
      m_code[ld_seg] = ld_code; m_rw[ld_seg] = ld_rw; m_dpl[ld_seg] = ld_dpl;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag, ev, ef, ec, el);
    ld_en = 0; req_valid = 0;
  endtask

  task automatic load(int s, logic [31:0] b, logic [31:0] l, logic p, logic c, logic w, logic [1:0] d);
    ld_en = 1; ld_seg = 3'(s); ld_base = b; ld_limit = l;
    ld_present = p; ld_code = c; ld_rw = w; ld_dpl = d;
  endtask

  task automatic req(int s, logic [1:0] k, logic [1:0] cpl, logic [31:0] o);
    req_valid = 1; req_seg = 3'(s); req_kind = k; req_cpl = cpl; req_off = o;
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_pres[i] = 0; m_code[i] = 0; m_rw[i] = 0; m_dpl[i] = 0;
    end
    rst = 1; ld_en = 0; req_valid = 0; ld_seg = 0; ld_base = 0; ld_limit = 0;
    ld_present = 0; ld_code = 0; ld_rw = 0; ld_dpl = 0; req_seg = 0; req_kind = 0;
    req_cpl = 0; req_off = 0;
    repeat (3) @(negedge clk);
    req(0, 2'd0, 2'd0, 32'h10);                     // R1: ignored while in reset
    @(posedge clk); @(negedge clk);
    compare("R1 reset outputs", 0, 0, 0, 0);
    req_valid = 0; rst = 0;

    for (int s = 0; s < 6; s++) begin req(s, 2'd0, 2'd0, 0); tick("R1 absent after reset"); end
    tick("R2 idle no response");

    load(1, 32'h1000, 32'hFF, 1, 1, 1, 0);
    req(1, 2'd2, 2'd0, 32'h10);                     tick("R11 same-cycle load sees old");
    req(1, 2'd2, 2'd0, 32'h10);                     tick("R3 R11 fetch after load");
    req(1, 2'd2, 2'd0, 32'hFF);                     tick("R4 offset equal limit");
    req(1, 2'd2, 2'd0, 32'h100);                    tick("R4 offset above limit");
    req(1, 2'd1, 2'd0, 32'h4);                      tick("R5 write to code");
    req(1, 2'd0, 2'd0, 32'h4);                      tick("R6 read of readable code");
    load(2, 32'h2000, 32'hFFF, 1, 1, 0, 0);         tick("R2 load only");
    req(2, 2'd0, 2'd0, 32'h8);                      tick("R6 read of exec-only code");
    req(2, 2'd2, 2'd0, 32'h8);                      tick("R6 fetch of exec-only code");
    load(3, 32'hFFFF_FFF0, 32'h100, 1, 0, 1, 3);    tick("R2 load only");
    req(3, 2'd0, 2'd3, 32'h20);                     tick("R3 wrap modulo 2^32");
    req(3, 2'd2, 2'd0, 32'h20);                     tick("R5 fetch from data");
    req(3, 2'd1, 2'd2, 32'h100);                    tick("R5 R4 write to writable data at limit");
    req(3, 2'd3, 2'd0, 32'h0);                      tick("R5 reserved kind");
    load(4, 32'h4000, 32'h10, 1, 0, 0, 1);          tick("R2 load only");
    req(4, 2'd1, 2'd0, 32'h0);                      tick("R5 write to read-only data");
    req(4, 2'd0, 2'd2, 32'h0);                      tick("R7 privilege too low");
    req(4, 2'd0, 2'd1, 32'h10);                     tick("R7 privilege equal");
    req(4, 2'd1, 2'd2, 32'h999);                    tick("R9 privilege before kind and limit");
    req(1, 2'd1, 2'd0, 32'h999);                    tick("R9 kind before limit");
    req(7, 2'd1, 2'd3, 32'h999);                    tick("R8 R9 bad register first");
    req(6, 2'd0, 2'd0, 32'h0);                      tick("R8 register 6");
    req(0, 2'd0, 2'd3, 32'h999);                    tick("R9 absent before privilege");
    load(5, 32'h0, 32'hFFFF_FFFF, 1, 0, 1, 3);      tick("R2 load only");
    req(5, 2'd0, 2'd3, 32'hFFFF_FFFF);              tick("R12 flat passes top offset");
    req(5, 2'd1, 2'd0, 32'h1234_5678);              tick("R12 flat write");
    load(3, 32'h0, 32'h0, 0, 0, 0, 0);              tick("R2 load only");
    req(3, 2'd0, 2'd0, 32'h0);                      tick("R8 absent after reload R10");

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 2) == 0)
        load(int'($urandom_range(0, 6)), ($urandom_range(0, 1) == 1) ? 32'hFFFF_FF00 : $urandom,
             32'($urandom_range(0, 4095)), $urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)));
      if ($urandom_range(0, 3) != 0)
        req(int'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
            32'($urandom_range(0, 4200)));
      tick("R9 random mix");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule